// File: doc/BRIEF.md
# Control Register File with Banked Stack Pointer

This block holds the processor's control registers and the live stack pointer, and gives access to them by a 4-bit control register index. The read port is combinational and indexed. The write port commits on the rising clock edge. The status word combines the current status byte, the saved status byte and the condition flag. The flag can also be read and written on its own. Two return addresses, a second-level saved status, two scratch words, and the interrupt-mode and user-mode stack pointer copies are also held here.

The status byte carries a stack-mode bit, bit 7. Whichever stack index matches the current mode is routed to the live stack pointer, and the other index reaches its banked copy. A control write to the status index that flips the mode bit exchanges the live pointer with the banks in the same edge. A byte-wide port gives the execution core direct access to the status byte. A plain port lets the general register file read and write the live stack pointer. All ports are simple control and data pins with no handshake. Every access completes in one cycle, so there is no back-pressure.

Top module: `ctrl_reg_file`

## Requirements
- R1: A synchronous active-high reset clears every stored register and the live stack pointer. After reset, every index reads 0, and `sp_rd` and `stat_byte_rd` are 0.
- R2: A read of index 0 returns saved_status[7,6,0] in bits 15,14,8, status[7,6] in bits 7,6, and the condition flag in bit 0. All other bits are 0.
- R3: A write to index 0 loads the saved status byte from data bits 15:8, the status byte from bits 7:0 and the condition flag from bit 0. Index 1 reads the flag in bit 0 (other bits 0), and a write to index 1 loads the flag from data bit 0 only.
- R4: When a write to index 0 changes the mode bit from 1 to 0, the user copy takes the live pointer and the live pointer takes the interrupt copy. A change from 0 to 1 makes the interrupt copy take the live pointer and the live pointer take the user copy. A write that keeps the mode bit leaves both copies and the live pointer unchanged.
- R5: With mode bit 0, index 2 (interrupt stack) accesses the live pointer and index 3 (user stack) accesses its stored copy. With mode bit 1, index 3 accesses the live pointer and index 2 its stored copy.
- R6: Indices 6 and 14 (return addresses) store all 32 written bits and read back with bit 0 forced to 0.
- R7: Index 8 (second-level saved status) is written from data bits 7:0 and reads back masked with 0xC1 in bits 7:0.
- R8: Indices 4 and 5 are plain 32-bit storage. Indices 7, 9 to 13 and 15 read as 0, and writes to them change no register.
- R9: `stat_byte_rd` shows the status byte with bit 0 replaced by the condition flag. A byte-port write loads the status byte and the flag from its bit 0, and it never exchanges the stack banks.
- R10: A read in the same cycle as a write to the same index returns the value held before that write.
- R11: `sp_rd` shows the live pointer, and `sp_wr_en` loads it from `sp_wd`. A control write that reaches the live pointer in the same cycle, by stack index or by bank exchange, takes priority over the `sp_wr_en` write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Control register read index |
| rd_data | output | 32 | Composed read data, combinational |
| wr_en | input | 1 | Control register write strobe |
| wr_idx | input | 4 | Control register write index |
| wr_data | input | 32 | Control register write data |
| stat_byte_rd | output | 8 | Status byte with condition flag in bit 0 |
| stat_byte_wr_en | input | 1 | Status byte write strobe |
| stat_byte_wd | input | 8 | Status byte write data |
| sp_rd | output | 32 | Live stack pointer |
| sp_wr_en | input | 1 | Live stack pointer write strobe |
| sp_wd | input | 32 | Live stack pointer write data |

## Verification
Reads are combinational. A value written on one rising edge is due on `rd_data`, `sp_rd` and `stat_byte_rd` just after that edge, and a bank exchange is complete after that same single edge. The bench drives every write on a falling edge, releases it on the next falling edge, and only then steps the read index through all sixteen values, settling briefly at each one before the following rising edge. For the same-cycle case, it samples the read while the write is still pending, before the edge, where the old value is due.

// File: rtl/cr_pkg.sv
`timescale 1ns/1ps
package cr_pkg;
  localparam int CR_IDX_W = 4;
  localparam int CR_NUM_IDX = 1 << CR_IDX_W;
  localparam int STAT_W = 8;
  localparam int MODE_BIT = 7;

  localparam logic [CR_IDX_W-1:0] IDX_STAT   = 4'd0;
  localparam logic [CR_IDX_W-1:0] IDX_FLAG   = 4'd1;
  localparam logic [CR_IDX_W-1:0] IDX_ISTK   = 4'd2;
  localparam logic [CR_IDX_W-1:0] IDX_USTK   = 4'd3;
  localparam logic [CR_IDX_W-1:0] IDX_AUX0   = 4'd4;
  localparam logic [CR_IDX_W-1:0] IDX_AUX1   = 4'd5;
  localparam logic [CR_IDX_W-1:0] IDX_RETA   = 4'd6;
  localparam logic [CR_IDX_W-1:0] IDX_SAVST2 = 4'd8;
  localparam logic [CR_IDX_W-1:0] IDX_RETA2  = 4'd14;

  localparam logic [STAT_W-1:0] STAT_RD_MASK  = 8'hC0;
  localparam logic [STAT_W-1:0] SAVED_RD_MASK = 8'hC1;

  // slot order inside the word bank
  localparam int WB_AUX0  = 0;
  localparam int WB_AUX1  = 1;
  localparam int WB_RETA  = 2;
  localparam int WB_RETA2 = 3;
  localparam int WB_SLOTS = 4;
endpackage

// File: rtl/cr_status_regs.sv
`timescale 1ns/1ps
module cr_status_regs
  import cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic              wr_flag,
  input  logic              wr_savst2,
  input  logic [15:0]       wd,
  input  logic              byte_wr_en,
  input  logic [STAT_W-1:0] byte_wd,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] saved_q,
  output logic [STAT_W-1:0] saved2_q,
  output logic              flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      saved_q  <= '0;
      saved2_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_stat) begin
        stat_q  <= wd[STAT_W-1:0];
        saved_q <= wd[2*STAT_W-1:STAT_W];
      end else if (byte_wr_en) begin
        stat_q  <= byte_wd;
      end
      if (wr_stat || wr_flag) flag_q <= wd[0];
      else if (byte_wr_en)    flag_q <= byte_wd[0];
      if (wr_savst2) saved2_q <= wd[STAT_W-1:0];
    end
  end

  // R3: flag takes bit 0 of a flag-index write
  a_r3_flag_write: assert property (@(posedge clk) disable iff (rst)
    wr_flag |=> flag_q == $past(wd[0]));

  // R9: byte port loads status byte and flag when no control write competes
  a_r9_byte_write: assert property (@(posedge clk) disable iff (rst)
    (byte_wr_en && !wr_stat && !wr_flag) |=>
      (stat_q == $past(byte_wd) && flag_q == $past(byte_wd[0])));

  // R7: second-level saved status only moves on its own write
  a_r7_saved2_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_savst2 |=> $stable(saved2_q));
endmodule

// File: rtl/cr_stack_bank.sv
`timescale 1ns/1ps
module cr_stack_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_now,
  input  logic              stat_wr,
  input  logic              mode_new,
  input  logic              istk_wr,
  input  logic              ustk_wr,
  input  logic [DATA_W-1:0] wd,
  input  logic              gp_wr_en,
  input  logic [DATA_W-1:0] gp_wd,
  output logic [DATA_W-1:0] live_q,
  output logic [DATA_W-1:0] istk_q,
  output logic [DATA_W-1:0] ustk_q
);
  logic swap;
  logic live_by_cr;
  logic istk_by_cr;
  logic ustk_by_cr;

  always_comb begin
    swap       = stat_wr && (mode_new != mode_now);
    live_by_cr = (istk_wr && !mode_now) || (ustk_wr && mode_now);
    istk_by_cr = istk_wr && mode_now;
    ustk_by_cr = ustk_wr && !mode_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      istk_q <= '0;
      ustk_q <= '0;
    end else begin
      if (swap)            live_q <= mode_now ? istk_q : ustk_q;
      else if (live_by_cr) live_q <= wd;
      else if (gp_wr_en)   live_q <= gp_wd;

      if (swap && !mode_now) istk_q <= live_q;
      else if (istk_by_cr)   istk_q <= wd;

      if (swap && mode_now)  ustk_q <= live_q;
      else if (ustk_by_cr)   ustk_q <= wd;
    end
  end

  // R4: leaving mode 1 banks the user pointer and restores the interrupt pointer
  a_r4_swap_down: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && mode_now && !mode_new) |=>
      (live_q == $past(istk_q) && ustk_q == $past(live_q)));

  // R4: entering mode 1 banks the interrupt pointer and restores the user pointer
  a_r4_swap_up: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !mode_now && mode_new) |=>
      (live_q == $past(ustk_q) && istk_q == $past(live_q)));

  // R4: a status write keeping the mode leaves the banks alone
  a_r4_no_swap: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && mode_now == mode_new) |=> ($stable(istk_q) && $stable(ustk_q)));

  // R11: general port loads the live pointer when nothing outranks it
  a_r11_gp_write: assert property (@(posedge clk) disable iff (rst)
    (gp_wr_en && !stat_wr && !istk_wr && !ustk_wr) |=> live_q == $past(gp_wd));
endmodule

// File: rtl/cr_word_bank.sv
`timescale 1ns/1ps
module cr_word_bank #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SLOTS-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wd,
  output logic [SLOTS-1:0][DATA_W-1:0] q
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)            q[s] <= '0;
      else if (wr_sel[s]) q[s] <= wd;
    end

    // R8: a slot changes only when selected
    a_r8_slot_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[s] |=> $stable(q[s]));
  end

  // R8: at most one slot written per cycle
  a_r8_one_slot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/ctrl_reg_file.sv
`timescale 1ns/1ps
module ctrl_reg_file
  import cr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CR_IDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [CR_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [STAT_W-1:0]   stat_byte_rd,
  input  logic                stat_byte_wr_en,
  input  logic [STAT_W-1:0]   stat_byte_wd,
  output logic [DATA_W-1:0]   sp_rd,
  input  logic                sp_wr_en,
  input  logic [DATA_W-1:0]   sp_wd
);
  localparam int PAD_W = DATA_W - 2*STAT_W;

  logic [CR_NUM_IDX-1:0] wsel;
  logic [STAT_W-1:0] stat_q, saved_q, saved2_q;
  logic flag_q;
  logic mode;
  logic [DATA_W-1:0] live_q, istk_q, ustk_q;
  logic [WB_SLOTS-1:0] wb_sel;
  logic [WB_SLOTS-1:0][DATA_W-1:0] wb_q;

  // one-hot write decode over all indices
  for (genvar i = 0; i < CR_NUM_IDX; i++) begin : g_wdec
    assign wsel[i] = wr_en && (wr_idx == CR_IDX_W'(i));
  end

  assign mode = stat_q[MODE_BIT];

  assign wb_sel[WB_AUX0]  = wsel[IDX_AUX0];
  assign wb_sel[WB_AUX1]  = wsel[IDX_AUX1];
  assign wb_sel[WB_RETA]  = wsel[IDX_RETA];
  assign wb_sel[WB_RETA2] = wsel[IDX_RETA2];

  cr_status_regs u_status (
    .clk        (clk),
    .rst        (rst),
    .wr_stat    (wsel[IDX_STAT]),
    .wr_flag    (wsel[IDX_FLAG]),
    .wr_savst2  (wsel[IDX_SAVST2]),
    .wd         (wr_data[15:0]),
    .byte_wr_en (stat_byte_wr_en),
    .byte_wd    (stat_byte_wd),
    .stat_q     (stat_q),
    .saved_q    (saved_q),
    .saved2_q   (saved2_q),
    .flag_q     (flag_q)
  );

  cr_stack_bank #(.DATA_W(DATA_W)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .mode_now (mode),
    .stat_wr  (wsel[IDX_STAT]),
    .mode_new (wr_data[MODE_BIT]),
    .istk_wr  (wsel[IDX_ISTK]),
    .ustk_wr  (wsel[IDX_USTK]),
    .wd       (wr_data),
    .gp_wr_en (sp_wr_en),
    .gp_wd    (sp_wd),
    .live_q   (live_q),
    .istk_q   (istk_q),
    .ustk_q   (ustk_q)
  );

  cr_word_bank #(.DATA_W(DATA_W), .SLOTS(WB_SLOTS)) u_words (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wb_sel),
    .wd     (wr_data),
    .q      (wb_q)
  );

  // read composition
  always_comb begin
    rd_data = '0;
    unique case (rd_idx)
      IDX_STAT:   rd_data = {{PAD_W{1'b0}}, saved_q & SAVED_RD_MASK,
                             (stat_q & STAT_RD_MASK) | {{(STAT_W-1){1'b0}}, flag_q}};
      IDX_FLAG:   rd_data = {{(DATA_W-1){1'b0}}, flag_q};
      IDX_ISTK:   rd_data = mode ? istk_q : live_q;
      IDX_USTK:   rd_data = mode ? live_q : ustk_q;
      IDX_AUX0:   rd_data = wb_q[WB_AUX0];
      IDX_AUX1:   rd_data = wb_q[WB_AUX1];
      IDX_RETA:   rd_data = {wb_q[WB_RETA][DATA_W-1:1], 1'b0};
      IDX_SAVST2: rd_data = {{(DATA_W-STAT_W){1'b0}}, saved2_q & SAVED_RD_MASK};
      IDX_RETA2:  rd_data = {wb_q[WB_RETA2][DATA_W-1:1], 1'b0};
      default:    rd_data = '0;
    endcase
  end

  assign stat_byte_rd = {stat_q[STAT_W-1:1], flag_q};
  assign sp_rd        = live_q;

  // R1: reset leaves pointer and status byte cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sp_rd == '0 && stat_byte_rd == '0));

  // R9: byte-port writes never move the banked pointer seen at the stack indices
  a_r9_byte_no_swap: assert property (@(posedge clk) disable iff (rst)
    (stat_byte_wr_en && !wr_en && !sp_wr_en) |=> $stable(sp_rd));

  // R8: a write to an unlisted index disturbs neither pointer nor status
  a_r8_unlisted_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == 4'd7 || wr_idx == 4'd15) && !sp_wr_en && !stat_byte_wr_en)
      |=> ($stable(sp_rd) && $stable(stat_byte_rd)));
endmodule

// File: tb/test_ctrl_reg_file.sv
`timescale 1ns/1ps
module test_ctrl_reg_file;
  localparam int CLK_PERIOD = 40;

  logic clk = 1'b0;
  logic rst;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [7:0]  stat_byte_rd;
  logic        stat_byte_wr_en;
  logic [7:0]  stat_byte_wd;
  logic [31:0] sp_rd;
  logic        sp_wr_en;
  logic [31:0] sp_wd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0]  m_stat, m_saved, m_saved2;
  logic        m_flag;
  logic [31:0] m_live, m_istk, m_ustk, m_aux0, m_aux1, m_reta, m_reta2;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_reg_file i_ctrl_reg_file (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .stat_byte_rd(stat_byte_rd), .stat_byte_wr_en(stat_byte_wr_en),
    .stat_byte_wd(stat_byte_wd), .sp_rd(sp_rd), .sp_wr_en(sp_wr_en), .sp_wd(sp_wd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_rd(input int idx);
    case (idx)
      0:  return ({24'h0, m_saved & 8'hC1} << 8) | {24'h0, m_stat & 8'hC0} | {31'h0, m_flag};
      1:  return {31'h0, m_flag};
      2:  return m_stat[7] ? m_istk : m_live;
      3:  return m_stat[7] ? m_live : m_ustk;
      4:  return m_aux0;
      5:  return m_aux1;
      6:  return m_reta & 32'hFFFF_FFFE;
      8:  return {24'h0, m_saved2 & 8'hC1};
      14: return m_reta2 & 32'hFFFF_FFFE;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int idx);
    case (idx)
      0: return "R2";
      1: return "R3";
      2, 3: return "R5";
      6, 14: return "R6";
      8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_cr_write(input int idx, input logic [31:0] d);
    case (idx)
      0: begin
        if (m_stat[7] != d[7]) begin
          if (m_stat[7]) begin m_ustk = m_live; m_live = m_istk; end
          else           begin m_istk = m_live; m_live = m_ustk; end
        end
        m_saved = d[15:8]; m_stat = d[7:0]; m_flag = d[0];
      end
      1: m_flag = d[0];
      2: if (!m_stat[7]) m_live = d; else m_istk = d;
      3: if (m_stat[7]) m_live = d; else m_ustk = d;
      4: m_aux0 = d;
      5: m_aux1 = d;
      6: m_reta = d;
      8: m_saved2 = d[7:0];
      14: m_reta2 = d;
      default: ;
    endcase
  endtask

  task automatic model_clear();
    m_stat = 0; m_saved = 0; m_saved2 = 0; m_flag = 0;
    m_live = 0; m_istk = 0; m_ustk = 0; m_aux0 = 0; m_aux1 = 0; m_reta = 0; m_reta2 = 0;
  endtask

  // called just after a falling edge with no write pending
  task automatic read_all(input string ctx);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      chk({req_of(i), " ", ctx}, rd_data, expect_rd(i));
    end
    chk({"R11 ", ctx}, sp_rd, m_live);
    chk({"R9 ", ctx}, {24'h0, stat_byte_rd}, {24'h0, m_stat[7:1], m_flag});
  endtask

  task automatic cr_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_cr_write(idx, d);
  endtask

  task automatic byte_write(input logic [7:0] d);
    @(negedge clk);
    stat_byte_wr_en = 1'b1; stat_byte_wd = d;
    @(negedge clk);
    stat_byte_wr_en = 1'b0;
    m_stat = d; m_flag = d[0];
  endtask

  task automatic gp_write(input logic [31:0] d);
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wd = d;
    @(negedge clk);
    sp_wr_en = 1'b0;
    m_live = d;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst = 1'b1; rd_idx = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    stat_byte_wr_en = 0; stat_byte_wd = 0; sp_wr_en = 0; sp_wd = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    read_all("R1 reset");

    // sweep: every index written with several patterns, all indices read after each
    for (int k = 0; k < 6; k++) begin
      for (int wi = 0; wi < 16; wi++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * (k * 16 + wi + 1);
        cr_write(wi, d);
        read_all("sweep");
      end
    end

    // R4: explicit bank exchanges in both directions and a no-change write
    cr_write(0, 32'h0000_0000);
    gp_write(32'h1111_0000);
    cr_write(2, 32'h2222_0000);   // mode 0: index 2 hits live
    cr_write(3, 32'h3333_0000);   // mode 0: index 3 hits user copy
    read_all("R5 mode0");
    cr_write(0, 32'h0000_0080);   // 0 -> 1
    chk("R4 up live", sp_rd, 32'h3333_0000);
    read_all("R4 up");
    cr_write(0, 32'h0000_00C1);   // stays 1
    chk("R4 hold live", sp_rd, 32'h3333_0000);
    read_all("R4 hold");
    cr_write(0, 32'h0000_0040);   // 1 -> 0
    chk("R4 down live", sp_rd, 32'h2222_0000);
    read_all("R4 down");

    // R9: byte port sets mode bit without an exchange
    byte_write(8'h81);
    chk("R9 no swap", sp_rd, 32'h2222_0000);
    read_all("R9 byte");
    byte_write(8'h3E);
    read_all("R9 byte2");

    // R10: same-cycle read of a pending write shows the old value
    cr_write(6, 32'h0000_1235);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd6; wr_data = 32'hDEAD_BEEF; rd_idx = 4'd6;
    #1;
    chk("R10 old value", rd_data, 32'h0000_1234);
    @(negedge clk);
    wr_en = 1'b0;
    model_cr_write(6, 32'hDEAD_BEEF);
    read_all("R10 after");

    // R11: control write to live pointer beats the general port
    cr_write(0, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'hAAAA_5555;
    sp_wr_en = 1'b1; sp_wd = 32'h0BAD_0BAD;
    @(negedge clk);
    wr_en = 1'b0; sp_wr_en = 1'b0;
    m_live = 32'hAAAA_5555;
    chk("R11 cr priority", sp_rd, 32'hAAAA_5555);
    // R11: bank exchange beats the general port
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0080;
    sp_wr_en = 1'b1; sp_wd = 32'h0BAD_0BAD;
    @(negedge clk);
    wr_en = 1'b0; sp_wr_en = 1'b0;
    model_cr_write(0, 32'h0000_0080);
    chk("R11 swap priority", sp_rd, m_live);
    read_all("R11");
    // R11: general port alone
    gp_write(32'hC0DE_F00D);
    read_all("R11 gp");

    // R1: reset again from a busy state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_clear();
    read_all("R1 re-reset");

    done = 1'b1;
    report();
  end
endmodule